// File: doc/BRIEF.md
# Power Button Override Controller

This block sits between a debounced front-panel power button and the supply control of a system. It passes button presses through to a downstream power-management agent and drives the active-low supply-enable output. The enable is 0 when the supply is on and 1 when it is off. If the operating system stops answering, the user can hold the button down. After a long enough hold the block keeps the button output asserted for a fixed extra interval, whatever the button does. It then switches the supply off on its own authority, raises a sticky status flag, pulses a clear to the power-button event status and marks the sleep state as soft-off.

All timing is measured in ticks of an external time base, so the same logic works at any tick rate. After every switch-off an off-time guard runs. During that window no button press may switch the supply back on. In legacy mode, with the supply on and VDD present, any press cuts the supply at once without going through the override sequence.

Top module: `pwr_btn_override`

## Requirements
- R1: While reset is asserted, onctl_o is 1 (supply off) and pwbtout_o, ovr_sts_o, pb_sts_clr_o and sleep_s45_o are all 0.
- R2: Outside the forced-stretch interval, pwbtout_o equals btn_i in the same cycle.
- R3: While the supply is on (onctl_o = 0), a press held for OVR_TICKS ticks enters the stretch interval. For the next STRETCH_TICKS ticks pwbtout_o stays 1 even if btn_i is 0.
- R4: On the tick that ends the stretch, the next cycle shows onctl_o = 1, ovr_sts_o = 1 and sleep_s45_o = 1, and pb_sts_clr_o is 1 for exactly that one cycle.
- R5: A press released before OVR_TICKS ticks have been counted leaves onctl_o and ovr_sts_o unchanged. The next press counts again from zero.
- R6: With onctl_o = 1 and the guard elapsed, a 0-to-1 edge of btn_i sets onctl_o to 0 and clears sleep_s45_o one cycle later.
- R7: After any 1-transition of onctl_o, button edges are ignored until GUARD_TICKS ticks have passed, and onctl_o stays 1.
- R8: With legacy_i = 1 and vdd_on_i = 1 while the supply is on, a 0-to-1 edge of btn_i sets onctl_o to 1 one cycle later. There is no stretch and ovr_sts_o does not change.
- R9: ovr_sts_o stays 1 until a cycle with sts_clr_i = 1 clears it. If an override completes in the same cycle as the clear, the set wins.
- R10: The press that turns the supply on does not count toward an override, however long it is held. Only a later, separate press can trigger one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle time-base tick |
| btn_i | input | 1 | Debounced power button, 1 = pressed |
| legacy_i | input | 1 | Legacy mode: a press switches off at once |
| vdd_on_i | input | 1 | VDD rail present |
| sts_clr_i | input | 1 | Write-one-to-clear strobe for ovr_sts_o |
| onctl_o | output | 1 | Supply enable, 0 = on, 1 = off |
| pwbtout_o | output | 1 | Button output to the power-management agent |
| ovr_sts_o | output | 1 | Sticky override status |
| pb_sts_clr_o | output | 1 | One-cycle clear of the power-button event status |
| sleep_s45_o | output | 1 | Sleep state forced to soft-off |

## Verification
The bench builds the block with OVR_TICKS = 6, STRETCH_TICKS = 3 and GUARD_TICKS = 5, and issues a tick every third clock. At these values a full override takes only about thirty cycles, and the guard window about fifteen. That puts these cases within a few hundred cycles:
- the stretch with an early release;
- a retry inside the guard;
- a turn-on press held past the override length;
- a legacy switch-off.

// File: rtl/pbo_pkg.sv
package pbo_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HOLD,
    ST_STRETCH,
    ST_RELEASE
  } pbo_state_e;

  // bits needed to count 0 .. limit-1
  function automatic int unsigned cnt_bits(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit);
  endfunction
endpackage

// File: rtl/pbo_tick_cnt.sv
module pbo_tick_cnt #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic en_i,
  input  logic tick_i,
  output logic done_o
);
  localparam int unsigned W = pbo_pkg::cnt_bits(LIMIT);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;

  assign done_o = en_i & tick_i & (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (clr_i)            cnt_q <= '0;
    else if (en_i && tick_i)   cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/pbo_guard.sv
module pbo_guard #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic tick_i,
  output logic ok_o
);
  localparam int unsigned W = pbo_pkg::cnt_bits(LIMIT);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;
  logic         busy_q;

  assign ok_o = ~busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q && tick_i) begin
      if (cnt_q == LAST) busy_q <= 1'b0;
      else               cnt_q  <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pbo_ctrl.sv
module pbo_ctrl
  import pbo_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       btn_i,
  input  logic       btn_rise_i,
  input  logic       legacy_i,
  input  logic       vdd_on_i,
  input  logic       sts_clr_i,
  input  logic       hold_done_i,
  input  logic       stretch_done_i,
  input  logic       guard_ok_i,
  output pbo_state_e state_o,
  output logic       onctl_o,
  output logic       ovr_sts_o,
  output logic       pb_sts_clr_o,
  output logic       sleep_s45_o,
  output logic       ovr_done_o,
  output logic       legacy_off_o,
  output logic       turn_on_o,
  output logic       off_evt_o
);
  pbo_state_e state_q, state_d;
  logic onctl_q, ovr_q, pbclr_q, s45_q;
  logic turn_on, legacy_off, ovr_done;

  always_comb begin
    state_d    = state_q;
    turn_on    = 1'b0;
    legacy_off = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (btn_rise_i) begin
          if (onctl_q) begin
            if (guard_ok_i) begin
              turn_on = 1'b1;
              state_d = ST_RELEASE;
            end
          end else if (legacy_i && vdd_on_i) begin
            legacy_off = 1'b1;
            state_d    = ST_RELEASE;
          end else begin
            state_d = ST_HOLD;
          end
        end
      end
      ST_HOLD: begin
        if (!btn_i)           state_d = ST_IDLE;
        else if (hold_done_i) state_d = ST_STRETCH;
      end
      ST_STRETCH: begin
        if (stretch_done_i) state_d = ST_RELEASE;
      end
      default: begin
        if (!btn_i) state_d = ST_IDLE;
      end
    endcase
  end

  assign ovr_done = (state_q == ST_STRETCH) & stretch_done_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      onctl_q <= 1'b1;
      ovr_q   <= 1'b0;
      pbclr_q <= 1'b0;
      s45_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      pbclr_q <= ovr_done;
      if (ovr_done || legacy_off) onctl_q <= 1'b1;
      else if (turn_on)           onctl_q <= 1'b0;
      if (ovr_done)       ovr_q <= 1'b1;
      else if (sts_clr_i) ovr_q <= 1'b0;
      if (ovr_done)     s45_q <= 1'b1;
      else if (turn_on) s45_q <= 1'b0;
    end
  end

  assign state_o      = state_q;
  assign onctl_o      = onctl_q;
  assign ovr_sts_o    = ovr_q;
  assign pb_sts_clr_o = pbclr_q;
  assign sleep_s45_o  = s45_q;
  assign ovr_done_o   = ovr_done;
  assign legacy_off_o = legacy_off;
  assign turn_on_o    = turn_on;
  assign off_evt_o    = ovr_done | legacy_off;
endmodule

// File: rtl/pwr_btn_override.sv
module pwr_btn_override
  import pbo_pkg::*;
#(
  parameter int unsigned OVR_TICKS     = 3900,
  parameter int unsigned STRETCH_TICKS = 200,
  parameter int unsigned GUARD_TICKS   = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic btn_i,
  input  logic legacy_i,
  input  logic vdd_on_i,
  input  logic sts_clr_i,
  output logic onctl_o,
  output logic pwbtout_o,
  output logic ovr_sts_o,
  output logic pb_sts_clr_o,
  output logic sleep_s45_o
);
  pbo_state_e state_w;
  logic btn_q, btn_rise_w;
  logic hold_done_w, stretch_done_w, guard_ok_w;
  logic ovr_done_w, legacy_off_w, turn_on_w, off_evt_w;
  logic stretch_w, hold_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) btn_q <= 1'b0;
    else        btn_q <= btn_i;
  end

  assign btn_rise_w = btn_i & ~btn_q;
  assign hold_w     = (state_w == ST_HOLD);
  assign stretch_w  = (state_w == ST_STRETCH);

  pbo_tick_cnt #(.LIMIT(OVR_TICKS)) u_hold (
    .clk(clk), .rst_n(rst_n), .clr_i(~hold_w), .en_i(hold_w & btn_i),
    .tick_i(tick_i), .done_o(hold_done_w)
  );

  pbo_tick_cnt #(.LIMIT(STRETCH_TICKS)) u_stretch (
    .clk(clk), .rst_n(rst_n), .clr_i(~stretch_w), .en_i(stretch_w),
    .tick_i(tick_i), .done_o(stretch_done_w)
  );

  pbo_guard #(.LIMIT(GUARD_TICKS)) u_guard (
    .clk(clk), .rst_n(rst_n), .start_i(off_evt_w), .tick_i(tick_i),
    .ok_o(guard_ok_w)
  );

  pbo_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .btn_i(btn_i), .btn_rise_i(btn_rise_w),
    .legacy_i(legacy_i), .vdd_on_i(vdd_on_i), .sts_clr_i(sts_clr_i),
    .hold_done_i(hold_done_w), .stretch_done_i(stretch_done_w),
    .guard_ok_i(guard_ok_w), .state_o(state_w), .onctl_o(onctl_o),
    .ovr_sts_o(ovr_sts_o), .pb_sts_clr_o(pb_sts_clr_o),
    .sleep_s45_o(sleep_s45_o), .ovr_done_o(ovr_done_w),
    .legacy_off_o(legacy_off_w), .turn_on_o(turn_on_w), .off_evt_o(off_evt_w)
  );

  assign pwbtout_o = btn_i | stretch_w;
endmodule

// File: rtl/pbo_checker.sv
module pbo_checker (
  input logic clk,
  input logic rst_n,
  input logic btn_i,
  input logic sts_clr_i,
  input logic onctl_o,
  input logic pwbtout_o,
  input logic ovr_sts_o,
  input logic pb_sts_clr_o,
  input logic sleep_s45_o,
  input logic stretch_w,
  input logic ovr_done_w,
  input logic guard_ok_w,
  input logic legacy_off_w,
  input logic turn_on_w
);
  AST_PWB_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    !stretch_w |-> (pwbtout_o == btn_i)); // R2

  AST_STRETCH_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    stretch_w |-> pwbtout_o); // R3

  AST_OVR_EFFECTS: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_done_w |=> (onctl_o && ovr_sts_o && pb_sts_clr_o && sleep_s45_o)); // R4

  AST_PBCLR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    pb_sts_clr_o |=> !pb_sts_clr_o); // R4

  AST_TURN_ON: assert property (@(posedge clk) disable iff (!rst_n)
    turn_on_w |=> (!onctl_o && !sleep_s45_o)); // R6

  AST_GUARD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(onctl_o) |-> $past(guard_ok_w)); // R7

  AST_LEGACY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (legacy_off_w && !sts_clr_i) |=> (onctl_o && ovr_sts_o == $past(ovr_sts_o))); // R8

  AST_STS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_sts_o && !sts_clr_i) |=> ovr_sts_o); // R9
endmodule

bind pwr_btn_override pbo_checker u_pbo_checker (
  .clk(clk), .rst_n(rst_n), .btn_i(btn_i), .sts_clr_i(sts_clr_i),
  .onctl_o(onctl_o), .pwbtout_o(pwbtout_o), .ovr_sts_o(ovr_sts_o),
  .pb_sts_clr_o(pb_sts_clr_o), .sleep_s45_o(sleep_s45_o),
  .stretch_w(stretch_w), .ovr_done_w(ovr_done_w), .guard_ok_w(guard_ok_w),
  .legacy_off_w(legacy_off_w), .turn_on_w(turn_on_w)
);

// File: tb/pwr_btn_override_tb_top.sv
`timescale 1ns/100ps
module pwr_btn_override_tb_top;
  localparam int OVR = 6;
  localparam int STR = 3;
  localparam int GRD = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, btn = 1'b0, legacy = 1'b0, vdd = 1'b1, sclr = 1'b0;
  logic onctl, pwb, ovr, pbclr, s45;

  int checks = 0, fails = 0, cyc = 0, pbclr_seen = 0;
  bit started = 0, finished = 0;

  always #2.5 clk = ~clk;

  pwr_btn_override #(.OVR_TICKS(OVR), .STRETCH_TICKS(STR), .GUARD_TICKS(GRD)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .btn_i(btn), .legacy_i(legacy),
    .vdd_on_i(vdd), .sts_clr_i(sclr), .onctl_o(onctl), .pwbtout_o(pwb),
    .ovr_sts_o(ovr), .pb_sts_clr_o(pbclr), .sleep_s45_o(s45)
  );

  // behavioural reference: mode 0 idle, 1 counting hold, 2 stretching, 3 waiting release
  int  m_mode = 0, m_hold = 0, m_str = 0, m_guard = 0;
  bit  m_on = 1, m_ovr = 0, m_pb = 0, m_s45 = 0, m_prev = 0;

  always @(posedge clk) begin
    started <= 1;
    if (!rst_n) begin
      m_mode = 0; m_hold = 0; m_str = 0; m_guard = 0;
      m_on = 1; m_ovr = 0; m_pb = 0; m_s45 = 0; m_prev = 0;
    end else begin
      bit ok, setv;
      ok = (m_guard == 0);
      setv = 0;
      m_pb = 0;
      if (tick && m_guard > 0) m_guard--;
      case (m_mode)
        0: if (btn && !m_prev) begin
             if (m_on) begin
               if (ok) begin m_on = 0; m_s45 = 0; m_mode = 3; end
             end else if (legacy && vdd) begin
               m_on = 1; m_guard = GRD; m_mode = 3;
             end else begin
               m_mode = 1; m_hold = 0;
             end
           end
        1: if (!btn) m_mode = 0;
           else if (tick) begin
             m_hold++;
             if (m_hold == OVR) begin m_mode = 2; m_str = 0; end
           end
        2: if (tick) begin
             m_str++;
             if (m_str == STR) begin
               m_on = 1; m_guard = GRD; m_ovr = 1; m_pb = 1; m_s45 = 1;
               m_mode = 3; setv = 1;
             end
           end
        default: if (!btn) m_mode = 0;
      endcase
      if (sclr && !setv) m_ovr = 0;
      m_prev = btn;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (pbclr) pbclr_seen++;
    if (started) begin
      chk("R4/R6/R7/R8 onctl model", onctl, m_on);
      chk("R2/R3 pwbtout model", pwb, btn | (m_mode == 2));
      chk("R9 ovr_sts model", ovr, m_ovr);
      chk("R4 pb_sts_clr model", pbclr, m_pb);
      chk("R4/R6 sleep_s45 model", s45, m_s45);
    end
  end

  // time base: one tick every third clock, changed after the falling edge
  always @(negedge clk) begin
    #1 tick <= (cyc % 3 == 0);
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic set_btn(input bit v);
    @(negedge clk); #1 btn = v;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    summary();
  end

  initial begin
    cycles(3);
    chk("R1 reset onctl", onctl, 1);
    chk("R1 reset pwbtout", pwb, 0);
    chk("R1 reset ovr_sts", ovr, 0);
    chk("R1 reset pb_sts_clr", pbclr, 0);
    chk("R1 reset sleep", s45, 0);
    @(negedge clk); #1 rst_n = 1;
    cycles(4);

    // R6: turn on from off
    set_btn(1); cycles(2);
    chk("R6 turn-on onctl", onctl, 0);
    chk("R2 pwbtout follows press", pwb, 1);
    set_btn(0); cycles(2);
    chk("R2 pwbtout follows release", pwb, 0);

    // R5: short press
    set_btn(1); cycles(3 * (OVR - 2)); set_btn(0); cycles(3);
    chk("R5 short press onctl", onctl, 0);
    chk("R5 short press ovr_sts", ovr, 0);
    set_btn(1); cycles(3 * (OVR - 2)); set_btn(0); cycles(3);
    chk("R5 recount onctl", onctl, 0);

    // R3/R4: long press, release during stretch
    pbclr_seen = 0;
    set_btn(1);
    for (int i = 0; i < 200 && m_mode != 2; i++) cycles(1);
    chk("R3 stretch reached", m_mode, 2);
    set_btn(0); cycles(1);
    chk("R3 pwbtout held in stretch", pwb, 1);
    for (int i = 0; i < 200 && onctl == 0; i++) cycles(1);
    cycles(1);
    chk("R4 onctl off", onctl, 1);
    chk("R4 ovr_sts set", ovr, 1);
    chk("R4 sleep s45", s45, 1);
    chk("R4 pb clear pulses", pbclr_seen, 1);
    chk("R3 pwbtout after stretch", pwb, 0);

    // R7: retry inside guard ignored
    set_btn(1); cycles(2);
    chk("R7 guard onctl", onctl, 1);
    set_btn(0); cycles(3 * GRD + 6);
    set_btn(1); cycles(2);
    chk("R6 after guard onctl", onctl, 0);
    chk("R6 after guard sleep", s45, 0);
    set_btn(0); cycles(2);

    // R9: sticky then clear
    chk("R9 sticky", ovr, 1);
    @(negedge clk); #1 sclr = 1;
    @(negedge clk); #1 sclr = 0;
    cycles(1);
    chk("R9 cleared", ovr, 0);

    // R8: legacy switch-off
    legacy = 1; vdd = 1;
    set_btn(1); cycles(2);
    chk("R8 legacy onctl", onctl, 1);
    chk("R8 legacy ovr_sts", ovr, 0);
    chk("R8 legacy pwbtout", pwb, 1);
    set_btn(0); legacy = 0; cycles(3 * GRD + 6);

    // R10: turn-on press held long
    set_btn(1); cycles(3 * (OVR + STR) + 12);
    chk("R10 held turn-on onctl", onctl, 0);
    chk("R10 held turn-on ovr_sts", ovr, 0);
    set_btn(0); cycles(4);
    chk("R10 after release onctl", onctl, 0);

    summary();
  end
endmodule